// File: doc/BRIEF.md
# Polled Serial Port with Register Window

This block is a byte-wide asynchronous serial port that a host drives through a small register window. The window has three registers: a data register, a control/status register and a clock register. The host sends a byte by writing it with a send flag set. It receives a byte by polling a receive flag, reading the byte and then writing the flag back to release the slot. The whole host handshake runs through two flag bits in the data register. Reading never clears anything.

The transmitter holds one pending byte in front of a frame shifter. The receiver has a one-byte landing slot. Both shifters run from a 16x oversampling tick supplied from outside, so the block itself has no rate divider. The clock register only stores the divider setting that software programs; logic outside the block uses it to produce the tick. The control register holds an interface-mode field, two ready-override bits and a sticky overrun flag.

Top module: `uart_regif`

## Requirements
- R1: After reset `txd` is high, the data register reads 0x0000_0200 (send-ready bit 9 = 1, receive flag bit 8 = 0), and the control and clock registers read 0.
- R2: Byte offset 0x00 selects the data register, 0x04 the control register and 0x08 the clock register; any other offset reads 0. Read data appears on `bus_rdata` in the cycle after `bus_ren` and holds its value while `bus_ren` is low.
- R3: When a good frame completes, bits 7:0 of the data register hold the byte and bit 8 reads 1. A read leaves bit 8 set. A data-register write with bit 8 = 1 clears it.
- R4: A data-register write with bit 9 = 1 while bit 9 reads 1 queues bits 7:0 for sending. Bit 9 reads 0 from the next cycle until the shifter takes the byte. A write with bit 9 = 0, or a write made while bit 9 reads 0, sends nothing.
- R5: If a byte completes while bit 8 is still set and is not being acknowledged in that cycle, the new byte replaces the old one and control bit 12 (overrun) becomes 1. Bit 12 stays 1 until a control write with bit 12 = 1 clears it.
- R6: Each frame on `txd` is a low start bit, then 8 data bits least significant first, then a high stop bit. Every bit lasts 16 `baud_tick` pulses.
- R7: The receiver confirms the start bit at its middle (8 ticks after the falling edge) and samples each later bit 16 ticks apart. A low pulse shorter than half a bit is ignored. A frame whose stop bit samples low is dropped without touching bit 8 or the stored byte, and the receiver waits for the line to return high.
- R8: Control bits 3:2 (interface mode; 1 = DTE, 2 = DCE), bit 7 (send-ready override) and bit 8 (receive-ready override) are read/write. The clock register stores bits 27:0, and bits 31:28 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Write strobe for the register window |
| bus_ren | input | 1 | Read strobe; data returns in the next cycle |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line (asynchronous) |
| txd | output | 1 | Serial transmit line |

## Verification
The assertions check the register-level flag rules on every cycle: the state at reset release, the send-ready bit dropping after an accepted write, the receive flag being set by a finished frame and cleared by an acknowledge, overrun being set and then staying set, and read data holding while there is no read strobe. Frame timing on the lines can only be shown by the bench scenarios. These cover the bit order and length of transmitted frames, mid-bit sampling of received frames, rejection of a short glitch and of a frame with a bad stop bit, and writes that must send nothing.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  // register byte offsets
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_CTRL = 4;
  localparam int unsigned OFS_CLK  = 8;
  // data register flags
  localparam int unsigned DAT_RXV_BIT = 8;
  localparam int unsigned DAT_TXR_BIT = 9;
  // control register fields
  localparam int unsigned CTL_MODE_LSB = 2;
  localparam int unsigned CTL_TXOVR    = 7;
  localparam int unsigned CTL_RXOVR    = 8;
  localparam int unsigned CTL_OVERRUN  = 12;
  // clock register stored width
  localparam int unsigned CLK_KEEP_W = 28;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_DTE  = 2'd1,
    MODE_DCE  = 2'd2,
    MODE_RSVD = 2'd3
  } if_mode_e;

  typedef struct packed {
    if_mode_e mode;
    logic     tx_ovr;
    logic     rx_ovr;
  } ctrl_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI
  } rx_state_e;
endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_data,
  output logic              load_ready,
  output logic              txd
);
  localparam int BITS = DATA_W + 2;
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(BITS + 1);

  logic            busy_q;
  logic [DATA_W:0] sh_q;
  logic [CW-1:0]   tcnt_q;
  logic [BW-1:0]   bcnt_q;
  logic            txd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      tcnt_q <= '0;
      bcnt_q <= '0;
      txd_q  <= 1'b1;
    end else if (!busy_q) begin
      if (load_valid) begin
        busy_q <= 1'b1;
        sh_q   <= {1'b1, load_data};
        tcnt_q <= '0;
        bcnt_q <= '0;
        txd_q  <= 1'b0;
      end
    end else if (tick) begin
      if (tcnt_q == CW'(OSR - 1)) begin
        tcnt_q <= '0;
        if (bcnt_q == BW'(BITS - 1)) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          txd_q  <= sh_q[0];
          sh_q   <= {1'b1, sh_q[DATA_W:1]};
          bcnt_q <= bcnt_q + 1'b1;
        end
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign load_ready = ~busy_q;
  assign txd        = txd_q;
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift import uart_regif_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W + 1);

  logic [1:0]        sync_q;
  logic              rx_s;
  rx_state_e         st_q;
  logic [CW-1:0]     tcnt_q;
  logic [BW-1:0]     bcnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              done_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd};
  end
  assign rx_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        RX_IDLE: if (tick && !rx_s) begin
          st_q   <= RX_START;
          tcnt_q <= '0;
        end
        RX_START: if (tick) begin
          if (tcnt_q == CW'(OSR/2 - 1)) begin
            tcnt_q <= '0;
            bcnt_q <= '0;
            st_q   <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (tcnt_q == CW'(OSR - 1)) begin
            tcnt_q <= '0;
            sh_q   <= {rx_s, sh_q[DATA_W-1:1]};
            if (bcnt_q == BW'(DATA_W - 1)) st_q <= RX_STOP;
            else bcnt_q <= bcnt_q + 1'b1;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (tcnt_q == CW'(OSR - 1)) begin
            tcnt_q <= '0;
            if (rx_s) begin
              done_q <= 1'b1;
              data_q <= sh_q;
              st_q   <= RX_IDLE;
            end else begin
              st_q   <= RX_WAITHI;
            end
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        RX_WAITHI: if (rx_s) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign done = done_q;
  assign data = data_q;
endmodule

// File: rtl/uart_regif.sv
module uart_regif import uart_regif_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32,
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              baud_tick,
  input  logic              rxd,
  output logic              txd
);
  logic sel_data, sel_ctrl, sel_clk;
  logic wr_data, wr_ctrl, wr_clk;
  logic tx_push, rx_ack;

  logic              hold_full_q;
  logic [DATA_W-1:0] hold_byte_q;
  logic              tx_ready;
  logic              sh_ready;

  logic              rx_done;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_flag_q;
  logic [DATA_W-1:0] rx_byte_q;
  logic              overrun_q;

  ctrl_t                 ctrl_q;
  logic [CLK_KEEP_W-1:0] clk_q;
  logic [BUS_W-1:0]      rd_mux;
  logic [BUS_W-1:0]      rdata_q;

  assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_clk  = (bus_addr == ADDR_W'(OFS_CLK));
  assign wr_data  = bus_wen & sel_data;
  assign wr_ctrl  = bus_wen & sel_ctrl;
  assign wr_clk   = bus_wen & sel_clk;
  assign tx_ready = ~hold_full_q;
  assign tx_push  = wr_data & bus_wdata[DAT_TXR_BIT] & tx_ready;
  assign rx_ack   = wr_data & bus_wdata[DAT_RXV_BIT];

  // transmit holding slot in front of the shifter
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full_q <= 1'b0;
      hold_byte_q <= '0;
    end else if (tx_push) begin
      hold_full_q <= 1'b1;
      hold_byte_q <= bus_wdata[DATA_W-1:0];
    end else if (hold_full_q && sh_ready) begin
      hold_full_q <= 1'b0;
    end
  end

  uart_tx_shift #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .tick       (baud_tick),
    .load_valid (hold_full_q),
    .load_data  (hold_byte_q),
    .load_ready (sh_ready),
    .txd        (txd)
  );

  uart_rx_shift #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk  (clk),
    .rst  (rst),
    .tick (baud_tick),
    .rxd  (rxd),
    .done (rx_done),
    .data (rx_byte)
  );

  // receive landing slot and overrun tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_flag_q <= 1'b0;
      rx_byte_q <= '0;
      overrun_q <= 1'b0;
    end else begin
      if (rx_done) begin
        rx_flag_q <= 1'b1;
        rx_byte_q <= rx_byte;
      end else if (rx_ack) begin
        rx_flag_q <= 1'b0;
      end
      if (rx_done && rx_flag_q && !rx_ack)
        overrun_q <= 1'b1;
      else if (wr_ctrl && bus_wdata[CTL_OVERRUN])
        overrun_q <= 1'b0;
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '{mode: MODE_NONE, tx_ovr: 1'b0, rx_ovr: 1'b0};
      clk_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.mode   <= if_mode_e'(bus_wdata[CTL_MODE_LSB +: 2]);
        ctrl_q.tx_ovr <= bus_wdata[CTL_TXOVR];
        ctrl_q.rx_ovr <= bus_wdata[CTL_RXOVR];
      end
      if (wr_clk) clk_q <= bus_wdata[CLK_KEEP_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_data) begin
      rd_mux[DATA_W-1:0]  = rx_byte_q;
      rd_mux[DAT_RXV_BIT] = rx_flag_q;
      rd_mux[DAT_TXR_BIT] = tx_ready;
    end else if (sel_ctrl) begin
      rd_mux[CTL_MODE_LSB +: 2] = ctrl_q.mode;
      rd_mux[CTL_TXOVR]         = ctrl_q.tx_ovr;
      rd_mux[CTL_RXOVR]         = ctrl_q.rx_ovr;
      rd_mux[CTL_OVERRUN]       = overrun_q;
    end else if (sel_clk) begin
      rd_mux[CLK_KEEP_W-1:0] = clk_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (bus_ren) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wen,
  input logic              bus_ren,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              txd,
  input logic              rx_flag,
  input logic              tx_ready,
  input logic              overrun,
  input logic              rx_done
);
  logic wr_dat, wr_ctl;
  assign wr_dat = bus_wen && (bus_addr == ADDR_W'(0));
  assign wr_ctl = bus_wen && (bus_addr == ADDR_W'(4));

  // R1
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (txd && !rx_flag && tx_ready && !overrun));
  // R2
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_ren |=> $stable(bus_rdata));
  // R3
  a_r3_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> rx_flag);
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_dat && bus_wdata[8] && !rx_done) |=> !rx_flag);
  // R4
  a_r4_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (wr_dat && bus_wdata[9] && tx_ready) |=> !tx_ready);
  // R5
  a_r5_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_flag && !(wr_dat && bus_wdata[8])) |=> overrun);
  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !(wr_ctl && bus_wdata[12])) |=> overrun);
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wen   (bus_wen),
  .bus_ren   (bus_ren),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .txd       (txd),
  .rx_flag   (rx_flag_q),
  .tx_ready  (tx_ready),
  .overrun   (overrun_q),
  .rx_done   (rx_done)
);

// File: tb/tb_uart_regif.sv
module tb_uart_regif;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0, bus_ren = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        baud_tick = 1'b0;
  logic        rxd = 1'b1;
  logic        txd;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  uart_regif dut (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .baud_tick(baud_tick), .rxd(rxd), .txd(txd)
  );

  always #4 clk = ~clk;

  initial begin : tick_gen
    int cnt = 0;
    forever begin
      @(negedge clk);
      baud_tick = (cnt == TICK_DIV - 1);
      cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
    end
  end

  function automatic logic [31:0] exp_data(logic trdy, logic rflag, logic [7:0] b);
    return (32'(trdy) << 9) | (32'(rflag) << 8) | 32'(b);
  endfunction
  function automatic logic [31:0] exp_ctrl(logic [1:0] m, logic txo, logic rxo, logic ovr);
    return (32'(m) << 2) | (32'(txo) << 7) | (32'(rxo) << 8) | (32'(ovr) << 12);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_rx(logic [7:0] b, logic stop);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT_CLK) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT_CLK) @(negedge clk);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // captures one frame from txd; frame_ok = found, start low, stop high
  task automatic grab_tx(output logic [7:0] b, output logic frame_ok);
    int  waitc = 0;
    logic st, sp;
    b = '0;
    while (txd !== 1'b0 && waitc < 3000) begin
      @(negedge clk);
      waitc++;
    end
    if (waitc >= 3000) begin
      frame_ok = 1'b0;
      return;
    end
    repeat (BIT_CLK/2) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (BIT_CLK) @(negedge clk);
      b[i] = txd;
    end
    repeat (BIT_CLK) @(negedge clk);
    sp = txd;
    frame_ok = (st == 1'b0) && (sp == 1'b1);
  endtask

  task automatic count_low(int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, keep;
    logic [7:0]  b, got, x, y;
    logic        ok;
    int          lows;
    void'($urandom(32'h1d5e_ed01));

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 txd idle", 32'(txd), 32'd1);
    rd(5'h00, v); chk("R1 data reset", v, exp_data(1, 0, 8'h00));
    rd(5'h04, v); chk("R1 ctrl reset", v, 32'h0);
    rd(5'h08, v); chk("R1 clock reset", v, 32'h0);

    // R8 control and clock registers
    wr(5'h04, exp_ctrl(2'd2, 1, 1, 0));
    rd(5'h04, v); chk("R8 ctrl DCE+overrides", v, 32'h0000_0188);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R8 ctrl all ones", v, exp_ctrl(2'd3, 1, 1, 0));
    wr(5'h04, exp_ctrl(2'd1, 0, 0, 0));
    rd(5'h04, v); chk("R8 ctrl DTE", v, 32'h0000_0004);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R8 clock upper bits", v, 32'h0FFF_FFFF);
    keep = $urandom();
    wr(5'h08, keep);
    rd(5'h08, v); chk("R8 clock random", v, keep & 32'h0FFF_FFFF);

    // R2 unmapped offsets and read hold
    rd(5'h0C, v); chk("R2 unmapped 0x0C", v, 32'h0);
    rd(5'h10, v); chk("R2 unmapped 0x10", v, 32'h0);
    rd(5'h08, v);
    wr(5'h04, exp_ctrl(2'd2, 1, 1, 0));
    @(negedge clk);
    bus_addr = 5'h00;
    repeat (3) @(negedge clk);
    chk("R2 rdata held without read", bus_rdata, keep & 32'h0FFF_FFFF);

    // R4/R6 random transmit frames
    for (int k = 0; k < 6; k++) begin
      b = 8'($urandom());
      if (k == 0) b = 8'h00;
      if (k == 1) b = 8'hFF;
      wr(5'h00, 32'h200 | 32'(b));
      grab_tx(got, ok);
      chk("R6 tx frame format", 32'(ok), 32'd1);
      chk("R6 tx byte LSB first", 32'(got), 32'(b));
    end
    repeat (BIT_CLK) @(negedge clk);

    // R4 write with bit 9 clear sends nothing
    wr(5'h00, 32'h0000_0055);
    count_low(BIT_CLK * 3, lows);
    chk("R4 no send without bit 9", 32'(lows), 32'd0);
    rd(5'h00, v); chk("R4 ready after ignored write", v & 32'h200, 32'h200);

    // R4 ready drops, write while busy ignored
    x = 8'h3C; y = 8'hC3;
    wr(5'h00, 32'h200 | 32'(x));
    repeat (6) @(negedge clk);
    wr(5'h00, 32'h200 | 32'(y));
    rd(5'h00, v); chk("R4 ready low while slot full", v & 32'h200, 32'h0);
    wr(5'h00, 32'h200 | 32'h0000_0077);
    grab_tx(got, ok);
    chk("R4 first queued byte", {23'd0, ok, got}, {23'd0, 1'b1, x});
    grab_tx(got, ok);
    chk("R4 second queued byte", {23'd0, ok, got}, {23'd0, 1'b1, y});
    count_low(BIT_CLK * 12, lows);
    chk("R4 write while busy dropped", 32'(lows), 32'd0);
    rd(5'h00, v); chk("R4 ready returns", v & 32'h200, 32'h200);

    // R3/R7 random receive frames
    for (int k = 0; k < 6; k++) begin
      b = 8'($urandom());
      if (k == 0) b = 8'h80;
      send_rx(b, 1'b1);
      rd(5'h00, v); chk("R3 rx byte and flag", v, exp_data(1, 1, b));
      rd(5'h00, v); chk("R3 read keeps flag", v, exp_data(1, 1, b));
      wr(5'h00, 32'h100);
      rd(5'h00, v); chk("R3 ack clears flag", v & 32'h300, 32'h200);
    end

    // R7 short glitch ignored
    @(negedge clk);
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CLK * 12) @(negedge clk);
    rd(5'h00, v); chk("R7 glitch ignored", v & 32'h100, 32'h0);

    // R7 bad stop bit drops frame, then recovers
    send_rx(8'hA5, 1'b0);
    repeat (BIT_CLK * 2) @(negedge clk);
    rd(5'h00, v); chk("R7 framing error dropped", v & 32'h100, 32'h0);
    send_rx(8'h5A, 1'b1);
    rd(5'h00, v); chk("R7 recovery after error", v, exp_data(1, 1, 8'h5A));
    wr(5'h00, 32'h100);

    // R5 overrun
    send_rx(8'h11, 1'b1);
    send_rx(8'h22, 1'b1);
    rd(5'h00, v); chk("R5 new byte overwrites", v, exp_data(1, 1, 8'h22));
    rd(5'h04, v); chk("R5 overrun set", v, exp_ctrl(2'd2, 1, 1, 1));
    wr(5'h04, exp_ctrl(2'd2, 1, 1, 0));
    rd(5'h04, v); chk("R5 overrun sticky on plain write", v, exp_ctrl(2'd2, 1, 1, 1));
    wr(5'h04, exp_ctrl(2'd2, 1, 1, 1));
    rd(5'h04, v); chk("R5 overrun cleared", v, exp_ctrl(2'd2, 1, 1, 0));
    rd(5'h00, v); chk("R5 rx flag untouched by ctrl write", v, exp_data(1, 1, 8'h22));
    wr(5'h00, 32'h100);
    rd(5'h00, v); chk("R3 final ack", v, exp_data(1, 0, 8'h22));

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule